// File: doc/BRIEF.md
# Integer Multiply and Divide Unit

A sequential arithmetic unit for integer multiplication, division and sign extension at three lane widths: a quarter, a half or all of the parameter `W`, which defaults to 32. With the default, the lanes are 8, 16 and 32 bits.

A multiply returns a double-width product, split into a high half and a low half. A divide takes a double-width dividend, split into a high half and a low half, and one single-width divisor. It returns the remainder in the high half and the quotient in the low half. Signed and unsigned forms of both exist. A sign-extension command fills the high half with copies of the operand's top lane bit.

Commands enter through a valid/ready handshake. The result port has no back-pressure: `res_valid` is a single-cycle pulse, and the result and status outputs hold their values until the next completion. While `in_ready` is low, a command on the input is not taken, and the source must hold it until `in_ready` returns. The multiplier uses shift-and-add and the divider uses restoring shift-subtract. Both handle one bit per clock.

Top module: `mdu_top`

## Requirements
- R1: During reset and right after it, `in_ready` is 1. `res_valid`, `res_hi`, `res_lo`, `res_carry`, `res_ovf` and `res_dive` are all 0.
- R2: A command is taken on a rising edge where `in_valid` and `in_ready` are both 1. `in_ready` is then 0 until the cycle in which `res_valid` pulses high, and `res_valid` stays high for exactly one cycle. Any `in_valid` while `in_ready` is 0 is ignored and produces no result.
- R3: Take edge E as the edge that accepts a command. `res_valid` is high after edge E+N+1, where N is the lane width for a multiply and twice the lane width for a divide. N is 0 for a sign extension and for a divide whose divisor is zero.
- R4: `in_size` 00 selects a lane of W/4 bits, 01 selects W/2 bits, and 1x selects W bits. Operand bits above the lane are ignored. Result bits above the lane are 0.
- R5: `in_op` 000 is an unsigned multiply, 001 a signed multiply, 010 an unsigned divide and 011 a signed divide. Any code with bit 2 set is a sign extension.
- R6: An unsigned multiply gives `opnd_lo`×`opnd_b` as {`res_hi`,`res_lo`}. `res_carry` and `res_ovf` are both 1 exactly when `res_hi` is nonzero.
- R7: A signed multiply gives the two's-complement product split the same way. `res_carry` and `res_ovf` are both 1 exactly when `res_hi` is not a copy of the top lane bit of `res_lo`.
- R8: An unsigned divide takes {`opnd_hi`,`opnd_lo`} as the dividend. It returns the quotient in `res_lo` and the remainder in `res_hi`.
- R9: A signed divide rounds the quotient toward zero, and a nonzero remainder takes the sign of the dividend. A quotient equal to the most negative lane value is still valid.
- R10: When the quotient does not fit the lane, `res_dive` is 1 and `res_hi`, `res_lo`, `res_carry` and `res_ovf` keep their previous values. In a signed divide, the most negative dividend divided by −1 is one such case.
- R11: A divisor of zero in the lane sets `res_dive`, and all results are kept unchanged.
- R12: A sign extension puts the lane value of `opnd_lo` in `res_lo` and fills `res_hi` with copies of its top lane bit.
- R13: `res_dive` is 0 after every completion that is not an error. Divides and sign extensions leave `res_carry` and `res_ovf` unchanged. All status outputs change only in a `res_valid` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Command present |
| in_ready | output | 1 | Unit idle, command can be taken |
| in_op | input | 3 | Operation code |
| in_size | input | 2 | Lane width select |
| opnd_hi | input | W | Dividend high half |
| opnd_lo | input | W | Multiplicand, dividend low half, or value to extend |
| opnd_b | input | W | Multiplier or divisor |
| res_valid | output | 1 | Single-cycle completion pulse |
| res_hi | output | W | Product high half, remainder or extension fill |
| res_lo | output | W | Product low half, quotient or extended value |
| res_carry | output | 1 | Upper product half is significant |
| res_ovf | output | 1 | Same rule as `res_carry` |
| res_dive | output | 1 | Divide error from a zero divisor or quotient overflow |

## Verification
Multiplies are run with products whose upper half is zero and with products whose upper half is significant. For signed multiplies, products that are valid sign extensions are set against ones that are not, so the two flag rules are told apart at every lane width. Divides are run with dividends whose high half is set, with quotients just inside and just outside the lane, with negative operands of both signs, with the most negative dividend over −1, and with a zero divisor. These patterns separate a correct sign and rounding treatment from an overflow or error path that leaves the previous results in place. Sign extension is tried with positive and negative values, with junk bits above the lane, and with the alternate opcode. A burst of unrelated commands while the unit is busy must be ignored. A long mixed sequence then checks that flags and results persist correctly from one command to the next, and that the completion cycle matches the rule in R3.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } mdu_state_e;

  localparam logic [1:0] LANE_QTR  = 2'b00;
  localparam logic [1:0] LANE_HALF = 2'b01;

  // lane width in bits for a size code; size 1x selects the full width
  function automatic int unsigned lane_bits(int unsigned xlen, logic [1:0] sz);
    case (sz)
      LANE_QTR:  return xlen / 4;
      LANE_HALF: return xlen / 2;
      default:   return xlen;
    endcase
  endfunction

endpackage

// File: rtl/mdu_operand_prep.sv
module mdu_operand_prep #(
  parameter int W = 32
) (
  input  logic           is_signed,
  input  logic           is_div,
  input  logic [1:0]     size,
  input  logic [W-1:0]   a_hi,
  input  logic [W-1:0]   a_lo,
  input  logic [W-1:0]   b,
  output logic [2*W-1:0] mag_a,
  output logic           neg_a,
  output logic [W-1:0]   mag_b,
  output logic           neg_b
);
  localparam int D = 2 * W;

  logic [D-1:0] div_mag [0:2];
  logic [W-1:0] mul_mag [0:2];
  logic [W-1:0] b_mag   [0:2];
  logic [2:0]   div_neg, mul_neg, b_neg;

  // one conditioning lane per supported width
  for (genvar k = 0; k < 3; k++) begin : g_lane
    localparam int WK = W >> (2 - k);
    logic [2*WK-1:0] cat;
    logic [D-1:0]    cat_x;
    logic [W-1:0]    lo_x, b_x;

    assign cat        = {a_hi[WK-1:0], a_lo[WK-1:0]};
    assign div_neg[k] = is_signed & cat[2*WK-1];
    assign mul_neg[k] = is_signed & a_lo[WK-1];
    assign b_neg[k]   = is_signed & b[WK-1];

    if (2 * WK < D) begin : g_cat_ext
      assign cat_x = {{(D - 2*WK){div_neg[k]}}, cat};
    end else begin : g_cat_full
      assign cat_x = cat;
    end

    if (WK < W) begin : g_word_ext
      assign lo_x = {{(W - WK){mul_neg[k]}}, a_lo[WK-1:0]};
      assign b_x  = {{(W - WK){b_neg[k]}}, b[WK-1:0]};
    end else begin : g_word_full
      assign lo_x = a_lo;
      assign b_x  = b;
    end

    assign div_mag[k] = div_neg[k] ? (~cat_x + D'(1)) : cat_x;
    assign mul_mag[k] = mul_neg[k] ? (~lo_x + W'(1)) : lo_x;
    assign b_mag[k]   = b_neg[k]   ? (~b_x + W'(1))  : b_x;
  end

  logic [1:0] idx;
  always_comb begin
    case (size)
      2'b00:   idx = 2'd0;
      2'b01:   idx = 2'd1;
      default: idx = 2'd2;
    endcase
    mag_a = is_div ? div_mag[idx] : {{W{1'b0}}, mul_mag[idx]};
    neg_a = is_div ? div_neg[idx] : mul_neg[idx];
    mag_b = b_mag[idx];
    neg_b = b_neg[idx];
  end

endmodule

// File: rtl/mdu_mul_core.sv
module mdu_mul_core #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           step,
  input  logic [W-1:0]   mcand,
  input  logic [W-1:0]   mplier,
  output logic [2*W-1:0] prod
);
  localparam int D = 2 * W;

  logic [D-1:0] mc_q;
  logic [W-1:0] mp_q;

  // shift-and-add: one multiplier bit per step, LSB first
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mc_q <= '0;
      mp_q <= '0;
      prod <= '0;
    end else if (load) begin
      mc_q <= D'(mcand);
      mp_q <= mplier;
      prod <= '0;
    end else if (step) begin
      if (mp_q[0]) prod <= prod + mc_q;
      mc_q <= mc_q << 1;
      mp_q <= mp_q >> 1;
    end
  end

endmodule

// File: rtl/mdu_div_core.sv
module mdu_div_core #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           step,
  input  logic [2*W-1:0] dividend,
  input  logic [W-1:0]   divisor,
  output logic [2*W-1:0] quo,
  output logic [W-1:0]   rem
);
  localparam int D = 2 * W;

  logic [W-1:0] dvs_q;
  logic [W:0]   part, diff;
  logic         fits;

  // restoring step: bring down one dividend bit, subtract when possible
  always_comb begin
    part = {rem, quo[D-1]};
    diff = part - {1'b0, dvs_q};
    fits = ~diff[W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dvs_q <= '0;
      quo   <= '0;
      rem   <= '0;
    end else if (load) begin
      dvs_q <= divisor;
      quo   <= dividend;
      rem   <= '0;
    end else if (step) begin
      rem <= fits ? diff[W-1:0] : part[W-1:0];
      quo <= {quo[D-2:0], fits};
    end
  end

endmodule

// File: rtl/mdu_top.sv
module mdu_top #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [2:0]   in_op,
  input  logic [1:0]   in_size,
  input  logic [W-1:0] opnd_hi,
  input  logic [W-1:0] opnd_lo,
  input  logic [W-1:0] opnd_b,
  output logic         res_valid,
  output logic [W-1:0] res_hi,
  output logic [W-1:0] res_lo,
  output logic         res_carry,
  output logic         res_ovf,
  output logic         res_dive
);
  import mdu_pkg::*;

  localparam int D  = 2 * W;
  localparam int CW = $clog2(D + 1);

  // ---------------- command decode ----------------
  logic is_sext, is_div, is_sgn, accept;
  assign is_sext = in_op[2];
  assign is_div  = ~in_op[2] & in_op[1];
  assign is_sgn  = in_op[0];

  mdu_state_e state;
  assign in_ready = (state == ST_IDLE);
  assign accept   = in_valid & in_ready;

  logic [D-1:0] p_mag_a;
  logic [W-1:0] p_mag_b;
  logic         p_neg_a, p_neg_b;

  mdu_operand_prep #(.W(W)) u_prep (
    .is_signed (is_sgn),
    .is_div    (is_div),
    .size      (in_size),
    .a_hi      (opnd_hi),
    .a_lo      (opnd_lo),
    .b         (opnd_b),
    .mag_a     (p_mag_a),
    .neg_a     (p_neg_a),
    .mag_b     (p_mag_b),
    .neg_b     (p_neg_b)
  );

  int unsigned  lw_in;
  logic [CW-1:0] iter_m1;
  logic [D-1:0]  dvd_aligned;
  logic          b_zero;

  always_comb begin
    lw_in       = lane_bits(W, in_size);
    iter_m1     = CW'((is_div ? 2 * lw_in : lw_in) - 1);
    dvd_aligned = p_mag_a << (D - 2 * lw_in);
    b_zero      = (p_mag_b == '0);
  end

  // ---------------- iterative cores ----------------
  logic          step;
  logic [D-1:0]  prod, quo;
  logic [W-1:0]  rem;

  assign step = (state == ST_RUN);

  mdu_mul_core #(.W(W)) u_mul (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (accept & ~is_div & ~is_sext),
    .step   (step),
    .mcand  (p_mag_a[W-1:0]),
    .mplier (p_mag_b),
    .prod   (prod)
  );

  mdu_div_core #(.W(W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept & is_div),
    .step     (step),
    .dividend (dvd_aligned),
    .divisor  (p_mag_b),
    .quo      (quo),
    .rem      (rem)
  );

  // ---------------- captured command ----------------
  logic [CW-1:0] cnt;
  logic          div_q, sext_q, sgn_q, neg_a_q, neg_b_q, zdiv_q;
  logic [1:0]    size_q;
  logic [W-1:0]  src_q;

  // ---------------- result formatting ----------------
  int unsigned  lw;
  logic [W-1:0] mask_w;
  logic [D-1:0] p_sgn, lim;
  logic [W-1:0] m_hi, m_lo, q_v, r_v, s_hi, s_lo;
  logic         m_sig, q_neg, q_fits;

  always_comb begin
    lw     = lane_bits(W, size_q);
    mask_w = W'((D'(1) << lw) - D'(1));
    // multiply
    p_sgn  = (neg_a_q ^ neg_b_q) ? (~prod + D'(1)) : prod;
    m_hi   = W'(p_sgn >> lw) & mask_w;
    m_lo   = p_sgn[W-1:0] & mask_w;
    m_sig  = sgn_q ? (m_hi != (p_sgn[lw-1] ? mask_w : '0)) : (m_hi != '0);
    // divide
    q_neg  = neg_a_q ^ neg_b_q;
    lim    = D'(1) << (lw - 1);
    if (!sgn_q)     q_fits = ((quo >> lw) == '0);
    else if (q_neg) q_fits = (quo <= lim);
    else            q_fits = (quo < lim);
    q_v    = (q_neg ? (~quo[W-1:0] + W'(1)) : quo[W-1:0]) & mask_w;
    r_v    = (neg_a_q ? (~rem + W'(1)) : rem) & mask_w;
    // sign extension
    s_lo   = src_q & mask_w;
    s_hi   = src_q[lw-1] ? mask_w : '0;
  end

  // ---------------- control and result registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      div_q     <= 1'b0;
      sext_q    <= 1'b0;
      sgn_q     <= 1'b0;
      neg_a_q   <= 1'b0;
      neg_b_q   <= 1'b0;
      zdiv_q    <= 1'b0;
      size_q    <= '0;
      src_q     <= '0;
      res_valid <= 1'b0;
      res_hi    <= '0;
      res_lo    <= '0;
      res_carry <= 1'b0;
      res_ovf   <= 1'b0;
      res_dive  <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            div_q   <= is_div;
            sext_q  <= is_sext;
            sgn_q   <= is_sgn;
            neg_a_q <= p_neg_a;
            neg_b_q <= p_neg_b;
            zdiv_q  <= is_div & b_zero;
            size_q  <= in_size;
            src_q   <= opnd_lo;
            cnt     <= iter_m1;
            state   <= (is_sext || (is_div && b_zero)) ? ST_FIN : ST_RUN;
          end
        end
        ST_RUN: begin
          if (cnt == '0) state <= ST_FIN;
          else           cnt   <= cnt - CW'(1);
        end
        ST_FIN: begin
          res_valid <= 1'b1;
          state     <= ST_IDLE;
          if (sext_q) begin
            res_hi   <= s_hi;
            res_lo   <= s_lo;
            res_dive <= 1'b0;
          end else if (div_q) begin
            if (zdiv_q || !q_fits) begin
              res_dive <= 1'b1;
            end else begin
              res_hi   <= r_v;
              res_lo   <= q_v;
              res_dive <= 1'b0;
            end
          end else begin
            res_hi    <= m_hi;
            res_lo    <= m_lo;
            res_carry <= m_sig;
            res_ovf   <= m_sig;
            res_dive  <= 1'b0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/mdu_checker.sv
module mdu_checker #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic         res_valid,
  input logic [W-1:0] res_hi,
  input logic [W-1:0] res_lo,
  input logic         res_carry,
  input logic         res_ovf,
  input logic         res_dive
);

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready); // R2

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid); // R2

  AST_IDLE_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> in_ready); // R2

  AST_DONE_FOLLOWS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(!in_ready)); // R3

  AST_ERR_KEEPS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_dive) |-> ($stable(res_hi) && $stable(res_lo))); // R10

  AST_STATUS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> ($stable(res_dive) && $stable(res_carry) && $stable(res_ovf))); // R13

endmodule

bind mdu_top mdu_checker #(.W(W)) u_mdu_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .res_valid (res_valid),
  .res_hi    (res_hi),
  .res_lo    (res_lo),
  .res_carry (res_carry),
  .res_ovf   (res_ovf),
  .res_dive  (res_dive)
);

// File: tb/tb_mdu_top.sv
`timescale 1ns/1ps
module tb_mdu_top;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [2:0]   in_op = '0;
  logic [1:0]   in_size = '0;
  logic [W-1:0] opnd_hi = '0, opnd_lo = '0, opnd_b = '0;
  logic         res_valid;
  logic [W-1:0] res_hi, res_lo;
  logic         res_carry, res_ovf, res_dive;

  always #2.5 clk = ~clk;

  mdu_top #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_size(in_size), .opnd_hi(opnd_hi), .opnd_lo(opnd_lo),
    .opnd_b(opnd_b), .res_valid(res_valid), .res_hi(res_hi), .res_lo(res_lo),
    .res_carry(res_carry), .res_ovf(res_ovf), .res_dive(res_dive)
  );

  typedef struct {
    logic [31:0] hi, lo;
    logic        cy, ov, err;
    int          lat, acc;
    string       tag;
  } exp_t;

  exp_t sb[$];
  int   nchk = 0, nbad = 0, cyc = 0;
  bit   ended = 0;
  logic [31:0] m_hi = '0, m_lo = '0;
  logic        m_cy = 1'b0, m_ov = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string what, logic [63:0] act, logic [63:0] expv);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", what, act, expv);
    end
  endtask

  task automatic wrap_up();
    if (!ended) begin
      ended = 1;
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  endtask

  function automatic logic signed [63:0] sx(logic [63:0] v, int n);
    logic signed [63:0] t;
    t = signed'(v << (64 - n));
    return t >>> (64 - n);
  endfunction

  // reference model, written from the requirements
  task automatic send(logic [2:0] op, logic [1:0] sz, logic [31:0] ah, logic [31:0] al,
                      logic [31:0] bb, string tag, int noise = 0);
    exp_t e;
    int w;
    logic [63:0] m, dd, up, q, r, p;
    logic signed [63:0] sp, sdd, sdv, sq, sr, lim;
    w = (sz == 2'b00) ? 8 : (sz == 2'b01) ? 16 : 32;
    m = (64'd1 << w) - 64'd1;
    e.hi = m_hi; e.lo = m_lo; e.cy = m_cy; e.ov = m_ov; e.err = 1'b0; e.tag = tag;
    if (op[2]) begin                       // R12 sign extension
      e.lo  = 32'(al & m);
      e.hi  = al[w-1] ? 32'(m) : 32'd0;
      e.lat = 1;
    end else if (!op[1]) begin             // R6 / R7 multiply
      e.lat = w + 1;
      if (!op[0]) begin
        p    = ({32'd0, al} & m) * ({32'd0, bb} & m);
        up   = p >> w;
        e.hi = 32'(up & m);
        e.lo = 32'(p & m);
        e.cy = (up != 0);
      end else begin
        sp   = sx({32'd0, al}, w) * sx({32'd0, bb}, w);
        e.lo = 32'(sp & m);
        e.hi = 32'((sp >> w) & m);
        e.cy = (sp != sx({32'd0, e.lo}, w));
      end
      e.ov = e.cy;
    end else begin                         // R8 .. R11 divide
      e.lat = 2 * w + 1;
      dd = ((({32'd0, ah} & m) << w) | ({32'd0, al} & m));
      if ((bb & m[31:0]) == 0) begin
        e.err = 1'b1; e.lat = 1;
        e.hi = m_hi; e.lo = m_lo;
      end else if (!op[0]) begin
        q = dd / ({32'd0, bb} & m);
        r = dd % ({32'd0, bb} & m);
        if (q > m) begin
          e.err = 1'b1;
        end else begin
          e.lo = 32'(q); e.hi = 32'(r);
        end
      end else begin
        sdd = sx(dd, 2 * w);
        sdv = sx({32'd0, bb} & m, w);
        lim = 64'sd1 <<< (w - 1);
        if (sdd == 64'sh8000_0000_0000_0000 && sdv == -64'sd1) begin
          e.err = 1'b1;
        end else begin
          sq = sdd / sdv;
          sr = sdd % sdv;
          if (sq < -lim || sq >= lim) e.err = 1'b1;
          else begin
            e.lo = 32'(sq & m); e.hi = 32'(sr & m);
          end
        end
      end
    end
    if (!e.err) begin
      m_hi = e.hi; m_lo = e.lo; m_cy = e.cy; m_ov = e.ov;
    end
    // drive the command
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_op = op; in_size = sz;
    opnd_hi = ah; opnd_lo = al; opnd_b = bb;
    @(negedge clk);
    e.acc = cyc;
    in_valid = 1'b0;
    sb.push_back(e);
    if (e.lat > 1)
      chk(in_ready == 1'b0, {"R2 busy after accept ", tag}, 64'(in_ready), 64'd0);
    for (int i = 0; i < noise; i++) begin   // R2 commands while busy are ignored
      in_valid = 1'b1; in_op = 3'b100; in_size = 2'b10; opnd_lo = 32'hDEAD_0000 + i;
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && res_valid && !ended) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R2 result without a command", 64'd1, 64'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(res_hi == e.hi, {e.tag, " res_hi"}, 64'(res_hi), 64'(e.hi));
        chk(res_lo == e.lo, {e.tag, " res_lo"}, 64'(res_lo), 64'(e.lo));
        chk(res_carry == e.cy, {e.tag, " res_carry"}, 64'(res_carry), 64'(e.cy));
        chk(res_ovf == e.ov, {e.tag, " res_ovf"}, 64'(res_ovf), 64'(e.ov));
        chk(res_dive == e.err, {e.tag, " R13 res_dive"}, 64'(res_dive), 64'(e.err));
        chk((cyc - e.acc) == e.lat, {e.tag, " R3 latency"}, 64'(cyc - e.acc), 64'(e.lat));
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    if (cyc > 150000 && !ended) begin
      nbad++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
      wrap_up();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b1 && res_valid == 1'b0, "R1 handshake in reset", {62'd0, in_ready, res_valid}, 64'h2);
    rst_n = 1'b1;
    @(negedge clk);
    chk(res_hi == 0 && res_lo == 0, "R1 results after reset", {res_hi, res_lo}, 64'd0);
    chk({res_carry, res_ovf, res_dive} == 3'b000, "R1 status after reset",
        64'({res_carry, res_ovf, res_dive}), 64'd0);

    send(3'b000, 2'b01, 32'h0, 32'h0000_1234, 32'h0000_0100, "R6 mulu16 upper significant");
    send(3'b000, 2'b10, 32'h0, 32'h0001_2345, 32'h0000_1000, "R6 mulu32 upper zero");
    send(3'b000, 2'b00, 32'h0, 32'hABCD_EFFF, 32'h1234_56FF, "R4 mulu8 junk above lane");
    send(3'b001, 2'b00, 32'h0, 32'h0000_0030, 32'h0000_0004, "R7 muls8 48x4 overflow");
    send(3'b001, 2'b01, 32'h0, 32'h0000_8760, 32'h0000_0100, "R7 muls16 negative overflow");
    send(3'b001, 2'b10, 32'h0, 32'd4823424, -32'sd423, "R7 muls32 fits");
    send(3'b001, 2'b00, 32'h0, 32'h0000_0080, 32'h0000_0080, "R7 muls8 min x min");
    send(3'b010, 2'b01, 32'h0000_0087, 32'h0000_6000, 32'h0000_0100, "R8 divu16 exact");
    send(3'b011, 2'b10, 32'h0, 32'h0000_0003, 32'h0000_0002, "R13 divide keeps flags");
    send(3'b010, 2'b01, 32'h0000_0087, 32'h0000_6002, 32'h0000_0010, "R10 divu16 quotient overflow");
    send(3'b011, 2'b10, 32'hFFFF_FFFF, 32'hFFFF_FFD0, 32'h0000_0005, "R9 divs32 -48/5");
    send(3'b011, 2'b01, 32'h0000_FFFF, 32'h0000_FDFF, 32'h0000_0100, "R9 divs16 -513/256");
    send(3'b011, 2'b00, 32'h0000_00FF, 32'h0000_0080, 32'h0000_0001, "R9 divs8 min quotient fits");
    send(3'b011, 2'b00, 32'h0000_00FF, 32'h0000_0080, 32'h0000_00FF, "R10 divs8 -128/-1");
    send(3'b011, 2'b00, 32'h0000_0080, 32'h0000_0000, 32'h0000_00FF, "R10 divs8 most negative/-1");
    send(3'b010, 2'b10, 32'h0000_0001, 32'h0000_0000, 32'h0000_0000, "R11 divide by zero");
    send(3'b011, 2'b00, 32'h0, 32'h0000_0007, 32'hFFFF_FF00, "R11 zero lane divisor");
    send(3'b100, 2'b10, 32'h0, 32'hFFFF_FF9B, 32'h0, "R12 sext32 negative");
    send(3'b111, 2'b00, 32'h0, 32'h1234_567F, 32'h0, "R12 sext8 positive junk above");
    send(3'b101, 2'b01, 32'h0, 32'h0000_8001, 32'h0, "R5 sext16 alt code");
    send(3'b000, 2'b10, 32'h0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R2 busy noise ignored", 5);

    for (int i = 0; i < 60; i++) begin
      logic [2:0] op;
      logic [1:0] sz;
      op = 3'($urandom_range(0, 4));
      sz = 2'($urandom_range(0, 2));
      send(op, sz, $urandom, $urandom, (i % 3 == 0) ? 32'($urandom_range(1, 300)) : $urandom,
           "R5 mixed sequence");
    end

    while (sb.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    wrap_up();
  end

endmodule